// File: doc/BRIEF.md
# CAN Receive Bit Sampler with Destuffing

This block sits right behind the receive pin of a CAN controller. It recovers the frame bit stream from one oversampled receive line. While the bus is idle it watches for the first dominant (logic 0) level. That clock edge becomes the time origin of the frame. At the same instant the block latches the nominal bit length, in system clocks, and the sample position, as a percentage of the bit. From then on it samples one raw bit per bit period, at a fixed offset inside each bit.

Each raw bit goes through a destuffing window that looks at the last six raw bits. A bit that breaks a run of five equal raw bits is a stuff bit. It is reported on a separate strobe, and it is not counted. Every other bit is handed to the downstream frame parser with its value and a destuffed index, where index 0 is the start-of-frame bit. When the parser has seen the end of the frame, it pulses a done input. That input returns the sampler to idle and clears all of its counters.

Resynchronisation on later edges and error signalling are left to other blocks.

Top module: `can_bit_sampler`

## Requirements
- R1: While idle, a recessive (1) receive level creates no strobe. The first clock edge that sees a dominant (0) level starts a frame, and that edge is called E0.
- R2: At E0 the block latches the bit length P from `bit_period` and the offset O. O is floor(P × `sample_pct` / 100), clamped to the range 1 to P−1; a P below 2 is taken as 2. Changing either input after E0 has no effect on the running frame.
- R3: Raw bit n (stuff bits included, n = 0, 1, …) is sampled at edge E0 + n·P + O. The matching strobe is high for exactly one cycle, the cycle after that edge.
- R4: Raw bit n with n ≥ 5 is a stuff bit exactly when raw bits n−5 … n−1 are all 0 and bit n is 1, or they are all 1 and bit n is 0. The window counts earlier stuff bits like any other raw bit.
- R5: A stuff bit pulses `stuff_strobe` and never `bit_valid`. `bit_value` shows its level, and the destuffed index does not advance.
- R6: Every non-stuff raw bit pulses `bit_valid` with its level on `bit_value`. `bit_index` is 0 for the first such bit of a frame and rises by one for each later one.
- R7: If destuffed bit 0 is recessive, `sof_warn` rises in the same cycle as that bit's `bit_valid` and stays high until `frame_done`. In a frame whose bit 0 is dominant it stays low.
- R8: `frame_done` returns the block to idle, suppresses a sample that falls on the same edge, and clears the destuffed index and the stuff history, so the next frame starts fresh.
- R9: After reset all outputs are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Receive line, 0 = dominant, 1 = recessive |
| bit_period | input | PERIOD_W | Nominal bit length in clocks, latched at frame start |
| sample_pct | input | PCT_W | Sample position in percent of the bit, latched at frame start |
| frame_done | input | 1 | Parser pulse: end of frame, return to idle |
| bit_valid | output | 1 | One-cycle strobe for a real (destuffed) frame bit |
| bit_value | output | 1 | Level of the last sampled raw bit |
| bit_index | output | IDX_W | Destuffed index of the last real bit |
| stuff_strobe | output | 1 | One-cycle strobe for a removed stuff bit |
| sof_warn | output | 1 | Start-of-frame bit was sampled recessive |

## Verification
The hardest case to reach from the ports is a `frame_done` pulse that lands on the very edge where a raw bit would be sampled. The suppression rule only matters in that one cycle. The bench computes the exact sample edge from E0, P and O, and raises `frame_done` one cycle earlier so that both fall on the same edge.

A second hard case is stale stuff history. One frame ends in a run of recessive bits, and the next frame follows at once with a dominant start bit. If the history were not cleared, that start bit would be taken for a stuff bit.

A recessive start bit is produced with a dominant glitch one clock long. The glitch starts a frame but has gone by the time bit 0 is sampled.

// File: rtl/can_smp_pkg.sv
package can_smp_pkg;
   // Number of equal raw bits after which the next opposite bit is stuffing.
   localparam int STUFF_RUN = 5;

   typedef enum logic {
      ST_IDLE    = 1'b0,
      ST_COLLECT = 1'b1
   } smp_state_e;
endpackage

// File: rtl/can_smp_rxsync.sv
module can_smp_rxsync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  sh_q[i] <= 1'b1;
               end else if (i == 0) begin
                  sh_q[i] <= d;
               end else begin
                  sh_q[i] <= sh_q[(i == 0) ? 0 : i-1];
               end
            end
         end
         assign q = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/can_smp_timer.sv
module can_smp_timer #(
   parameter int PW    = 16,
   parameter int PCT_W = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [PW-1:0] period_in,
   input  logic [PCT_W-1:0] pct_in,
   output logic          tick
);
   localparam int OW = PW + PCT_W;
   localparam logic [PW-1:0] MIN_PER = PW'(2);
   localparam logic [OW-1:0] HUNDRED = OW'(100);

   logic [PW-1:0] per_eff;
   logic [OW-1:0] per_ext, prod, raw_off, off_sel;
   logic [PW-1:0] per_q, pos_q;
   logic [OW-1:0] off_q;

   always_comb begin
      per_eff = (period_in < MIN_PER) ? MIN_PER : period_in;
      per_ext = OW'(per_eff);
      prod    = per_ext * OW'(pct_in);
      raw_off = prod / HUNDRED;
      if (raw_off == '0) begin
         off_sel = OW'(1);
      end else if (raw_off >= per_ext) begin
         off_sel = per_ext - OW'(1);
      end else begin
         off_sel = raw_off;
      end
   end

   // pos_q holds (clocks since the start edge) modulo the latched period.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q <= MIN_PER;
         off_q <= OW'(1);
         pos_q <= '0;
      end else if (load) begin
         per_q <= per_eff;
         off_q <= off_sel;
         pos_q <= PW'(1);
      end else if (pos_q == per_q - PW'(1)) begin
         pos_q <= '0;
      end else begin
         pos_q <= pos_q + PW'(1);
      end
   end

   assign tick = (OW'(pos_q) == off_q);
endmodule

// File: rtl/can_smp_destuff.sv
module can_smp_destuff #(
   parameter int RUN = can_smp_pkg::STUFF_RUN
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic shift,
   input  logic bit_in,
   output logic is_stuff
);
   localparam int CW = $clog2(RUN + 1);
   localparam logic [CW-1:0] FULL = CW'(RUN);

   // hist_q holds the previous RUN raw bits. Together with bit_in it forms
   // the window of RUN+1 raw bits that decides on stuffing.
   logic [RUN-1:0] hist_q;
   logic [CW-1:0]  seen_q;
   logic           all_opp;

   always_comb begin
      all_opp = 1'b1;
      for (int i = 0; i < RUN; i++) begin
         if (hist_q[i] == bit_in) all_opp = 1'b0;
      end
   end

   assign is_stuff = (seen_q == FULL) && all_opp;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         hist_q <= '0;
         seen_q <= '0;
      end else if (shift) begin
         hist_q <= {hist_q[RUN-2:0], bit_in};
         if (seen_q != FULL) seen_q <= seen_q + CW'(1);
      end
   end
endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler
   import can_smp_pkg::*;
#(
   parameter int PERIOD_W       = 16,
   parameter int PCT_W          = 7,
   parameter int IDX_W          = 8,
   parameter int RX_SYNC_STAGES = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_line,
   input  logic [PERIOD_W-1:0] bit_period,
   input  logic [PCT_W-1:0]    sample_pct,
   input  logic                frame_done,
   output logic                bit_valid,
   output logic                bit_value,
   output logic [IDX_W-1:0]    bit_index,
   output logic                stuff_strobe,
   output logic                sof_warn
);
   generate
      if (PERIOD_W < 2) begin : g_bad_pw
         $error("PERIOD_W must be at least 2");
      end
      if (PCT_W < 7) begin : g_bad_pct
         $error("PCT_W must hold the value 100");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("IDX_W must be positive");
      end
      if (RX_SYNC_STAGES < 0) begin : g_bad_sync
         $error("RX_SYNC_STAGES must not be negative");
      end
   endgenerate

   smp_state_e       state_q;
   logic             rx_s;
   logic             tick;
   logic             is_stuff;
   logic             start;
   logic             sample;
   logic [IDX_W-1:0] idx_cnt_q;

   logic             valid_q, stuff_q, value_q, warn_q;
   logic [IDX_W-1:0] idx_q;

   can_smp_rxsync #(.STAGES(RX_SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_line),
      .q     (rx_s)
   );

   assign start  = (state_q == ST_IDLE) && !rx_s && !frame_done;
   assign sample = (state_q == ST_COLLECT) && tick && !frame_done;

   can_smp_timer #(.PW(PERIOD_W), .PCT_W(PCT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .period_in (bit_period),
      .pct_in    (sample_pct),
      .tick      (tick)
   );

   can_smp_destuff #(.RUN(STUFF_RUN)) u_destuff (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start || frame_done),
      .shift    (sample),
      .bit_in   (rx_s),
      .is_stuff (is_stuff)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else if (frame_done) begin
         state_q <= ST_IDLE;
      end else if (start) begin
         state_q <= ST_COLLECT;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q   <= 1'b0;
         stuff_q   <= 1'b0;
         value_q   <= 1'b0;
         warn_q    <= 1'b0;
         idx_q     <= '0;
         idx_cnt_q <= '0;
      end else begin
         valid_q <= sample && !is_stuff;
         stuff_q <= sample && is_stuff;
         if (sample) value_q <= rx_s;
         if (frame_done || start) begin
            idx_cnt_q <= '0;
            warn_q    <= 1'b0;
         end else if (sample && !is_stuff) begin
            idx_q     <= idx_cnt_q;
            idx_cnt_q <= idx_cnt_q + IDX_W'(1);
            if (idx_cnt_q == '0 && rx_s) warn_q <= 1'b1;
         end
      end
   end

   assign bit_valid    = valid_q;
   assign stuff_strobe = stuff_q;
   assign bit_value    = value_q;
   assign bit_index    = idx_q;
   assign sof_warn     = warn_q;
endmodule

// File: rtl/can_smp_chk.sv
module can_smp_chk #(
   parameter int IDX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_done,
   input logic             bit_valid,
   input logic             bit_value,
   input logic [IDX_W-1:0] bit_index,
   input logic             stuff_strobe,
   input logic             sof_warn
);
   logic             strobe;
   logic [2:0]       run_q;
   logic             last_q;
   logic             any_raw_q;
   logic             have_idx_q;
   logic [IDX_W-1:0] last_idx_q;

   assign strobe = bit_valid || stuff_strobe;

   // Observer state built only from the output strobes.
   always_ff @(posedge clk) begin
      if (!rst_n || frame_done) begin
         run_q      <= '0;
         last_q     <= 1'b0;
         any_raw_q  <= 1'b0;
         have_idx_q <= 1'b0;
         last_idx_q <= '0;
      end else if (strobe) begin
         any_raw_q <= 1'b1;
         last_q    <= bit_value;
         if (!any_raw_q || bit_value != last_q) run_q <= 3'd1;
         else if (run_q != 3'd7) run_q <= run_q + 3'd1;
         if (bit_valid) begin
            have_idx_q <= 1'b1;
            last_idx_q <= bit_index;
         end
      end
   end

   AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      !(bit_valid && stuff_strobe)); // R5

   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe); // R3

   AST_STUFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      stuff_strobe |-> (any_raw_q && run_q == 3'd5 && bit_value != last_q)); // R4

   AST_STUFF_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && any_raw_q && run_q == 3'd5) |-> (bit_value == last_q)); // R4

   AST_IDX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && !have_idx_q) |-> (bit_index == '0)); // R6

   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && have_idx_q) |-> (bit_index == last_idx_q + IDX_W'(1))); // R6

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !strobe); // R8

   AST_WARN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sof_warn) |-> (bit_valid && bit_value && bit_index == '0)); // R7
endmodule

bind can_bit_sampler can_smp_chk #(.IDX_W(IDX_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frame_done   (frame_done),
   .bit_valid    (bit_valid),
   .bit_value    (bit_value),
   .bit_index    (bit_index),
   .stuff_strobe (stuff_strobe),
   .sof_warn     (sof_warn)
);

// File: tb/tb_can_bit_sampler.sv
module tb_can_bit_sampler;
   localparam int PW = 16;
   localparam int CW = 7;
   localparam int IW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_line = 1'b1;
   logic [PW-1:0] bit_period = PW'(20);
   logic [CW-1:0] sample_pct = CW'(70);
   logic          frame_done = 1'b0;
   logic          bit_valid, bit_value, stuff_strobe, sof_warn;
   logic [IW-1:0] bit_index;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   // Event log filled from the outputs at every falling edge.
   int   ev_n = 0;
   int   ev_cyc[256];
   bit   ev_stf[256];
   logic ev_val[256];
   int   ev_idx[256];

   bit seq[64];
   int nb;

   can_bit_sampler #(.PERIOD_W(PW), .PCT_W(CW), .IDX_W(IW)) dut (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_period(bit_period),
      .sample_pct(sample_pct), .frame_done(frame_done), .bit_valid(bit_valid),
      .bit_value(bit_value), .bit_index(bit_index), .stuff_strobe(stuff_strobe),
      .sof_warn(sof_warn)
   );

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && (bit_valid || stuff_strobe) && ev_n < 256) begin
         ev_cyc[ev_n] = cyc;
         ev_stf[ev_n] = stuff_strobe;
         ev_val[ev_n] = bit_value;
         ev_idx[ev_n] = int'(bit_index);
         ev_n = ev_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   function automatic int exp_off(input int p, input int pct);
      int pe = (p < 2) ? 2 : p;
      int o = pe * pct / 100;
      if (o < 1) o = 1;
      if (o >= pe) o = pe - 1;
      return o;
   endfunction

   task automatic load(input string s);
      nb = s.len();
      for (int i = 0; i < nb; i++) seq[i] = (s[i] == 8'h31);
   endtask

   // Drive one raw frame, end it with frame_done, compare every strobe.
   task automatic run_frame(input string s, input int p, input int pct,
                            input bit change, input string tag);
      int base, c0, o, idx, k;
      bit stf;
      load(s);
      base = ev_n;
      @(negedge clk);
      bit_period = PW'(p);
      sample_pct = CW'(pct);
      c0 = cyc + 1;
      for (int n = 0; n < nb; n++) begin
         rx_line = seq[n];
         if (change && n == nb / 2) begin
            bit_period = PW'(p + 7);       // R2: ignored mid-frame
            sample_pct = CW'((pct + 40) % 100);
         end
         repeat (p) @(negedge clk);
      end
      chk(sof_warn == 1'b0, "R7", {tag, " warn low for dominant start"}, int'(sof_warn), 0);
      rx_line = 1'b1;
      frame_done = 1'b1;
      @(negedge clk);
      frame_done = 1'b0;
      repeat (p + 2) @(negedge clk);
      o = exp_off(p, pct);
      chk(ev_n - base == nb, "R3", {tag, " strobe count"}, ev_n - base, nb);
      idx = 0;
      for (int n = 0; n < nb; n++) begin
         stf = 1'b0;
         if (n >= 5) begin
            stf = 1'b1;
            for (int j = n - 5; j < n; j++) if (seq[j] == seq[n]) stf = 1'b0;
         end
         k = base + n;
         if (k < ev_n) begin
            chk(ev_cyc[k] == c0 + n * p + o, "R3", {tag, " sample cycle"},
                ev_cyc[k] - c0, n * p + o);
            chk(ev_stf[k] == stf, "R4", {tag, " stuff classification"},
                int'(ev_stf[k]), int'(stf));
            chk(ev_val[k] == seq[n], "R6", {tag, " bit value"},
                int'(ev_val[k]), int'(seq[n]));
            if (!stf) begin
               chk(ev_idx[k] == idx, "R6", {tag, " destuffed index"}, ev_idx[k], idx);
            end
         end
         if (!stf) idx++;
      end
      bit_period = PW'(p);
      sample_pct = CW'(pct);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bit_valid == 0 && stuff_strobe == 0, "R9", "strobes after reset",
          int'(bit_valid) + int'(stuff_strobe), 0);
      chk(bit_index == 0 && sof_warn == 0 && bit_value == 0, "R9", "outputs after reset",
          int'(bit_index) + int'(sof_warn) + int'(bit_value), 0);
   endtask

   task automatic t_idle();
      int base = ev_n;
      rx_line = 1'b1;
      repeat (300) @(negedge clk);
      chk(ev_n == base, "R1", "no strobe on idle recessive line", ev_n - base, 0);
   endtask

   // frame_done lands on the sample edge of raw bit 1: that sample is dropped.
   task automatic t_abort();
      int base, c0, p, o;
      p = 10;
      o = exp_off(10, 40);
      base = ev_n;
      @(negedge clk);
      bit_period = PW'(p);
      sample_pct = CW'(40);
      rx_line = 1'b0;
      c0 = cyc + 1;
      repeat (p) @(negedge clk);
      rx_line = 1'b1;
      while (cyc < c0 + p + o - 1) @(negedge clk);
      frame_done = 1'b1;
      @(negedge clk);
      frame_done = 1'b0;
      repeat (3 * p) @(negedge clk);
      chk(ev_n - base == 1, "R8", "sample on done edge suppressed", ev_n - base, 1);
      if (ev_n - base >= 1) begin
         chk(ev_cyc[base] == c0 + o, "R3", "abort frame bit0 cycle", ev_cyc[base] - c0, o);
      end
   endtask

   // One-clock dominant glitch: start detected, bit 0 sampled recessive.
   task automatic t_glitch();
      int base, c0;
      base = ev_n;
      @(negedge clk);
      bit_period = PW'(10);
      sample_pct = CW'(70);
      rx_line = 1'b0;
      c0 = cyc + 1;
      @(negedge clk);
      rx_line = 1'b1;
      repeat (19) @(negedge clk);
      chk(ev_n - base == 2, "R7", "glitch frame strobe count", ev_n - base, 2);
      if (ev_n - base == 2) begin
         chk(ev_cyc[base] == c0 + 7 && ev_val[base] == 1'b1 && ev_idx[base] == 0,
             "R7", "recessive start bit delivered", ev_cyc[base] - c0, 7);
         chk(ev_idx[base + 1] == 1, "R6", "glitch frame second index", ev_idx[base + 1], 1);
      end
      chk(sof_warn == 1'b1, "R7", "warning raised", int'(sof_warn), 1);
      frame_done = 1'b1;
      @(negedge clk);
      frame_done = 1'b0;
      @(negedge clk);
      chk(sof_warn == 1'b0, "R7", "warning cleared by frame_done", int'(sof_warn), 0);
      repeat (12) @(negedge clk);
   endtask

   initial begin
      #(20 * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      t_reset();
      t_idle();
      run_frame("0110100110101", 20, 70, 1'b0, "A");          // R6 plain bits
      run_frame("0000011111011111", 16, 50, 1'b0, "B");       // R4 R5 chained stuffing
      run_frame("0101010", 12, 0, 1'b0, "C");                 // R8 fresh history, R2 clamp low
      run_frame("0111110000011", 10, 100, 1'b1, "D");         // R2 latch, clamp high
      t_abort();
      run_frame("00000100000", 25, 87, 1'b0, "E");            // R4 run broken by stuff bit
      t_glitch();
      t_idle();
      summary();
   end
endmodule